// File: doc/BRIEF.md
# Time-Interval Measurement Controller

This block measures how many clock cycles pass between a start event and a stop event. Each event is picked from a 64-entry event bus and has its own polarity bit. A two-bit command starts a measurement, clears the result or aborts a run. A state machine steps through clear, arm, wait-for-start and wait-for-stop phases, and it reports its position as a fixed 6-bit state code. The counter runs in the controller's own clock domain and advances once per cycle. A run ends at a qualifying stop event or when a selectable result bit becomes set. The second case is saturation.

An optional skip counter lets a run pass over a programmed number of stop events before the stop that ends it. This supports N-period and Nth-event measurements. Software can overwrite the remaining skip count while a run is in progress. The event lines, the configuration and the command are all treated as synchronous to `clk`. The command is a one-cycle strobe with no back-pressure: a command that arrives in a state that does not accept it is dropped.

Top module: `time_interval_meter`

## Requirements
- R1: While reset is held, the state code is POR (0x0F), both flags are 0 and the result is 0. One clock edge after reset is released, the state code is IDLE (0x06).
- R2: Command codes are: 0 = clear, 1 = run with an edge-qualified start, 2 = run with a level start, 3 = abort. Only codes 1 and 2 take the block out of IDLE. An accepted abort goes to FORCE_STOP (0x2E) for one cycle and then to IDLE, and it sets no done flag.
- R3: An abort given in CLR_CNT (0x07) or WAIT_CLR_CNT_DONE (0x16) is ignored. A run always passes CLR_CNT then WAIT_CLR_CNT_DONE, each for one cycle.
- R4: An edge-qualified run goes through START_FALL (0x1E) until the start source is inactive. It then waits in WAIT_START and begins counting at the first clock edge that samples the start source active.
- R5: A level run goes straight to WAIT_START and begins counting at the first edge that samples the start source active, even if the source was already active before the command.
- R6: A source is active when bus[sel] XOR pol is 1, where pol 0 means active-high and pol 1 means active-low. Code 62 selects the prescaler input and code 63 is a constant-0 line. A stop event is a change of the qualified stop from inactive to active between two sampling edges. The result equals the number of clock edges from the start-sampling edge to the stop-sampling edge.
- R7: A limit value L in 3..15 selects result bit L+9. Any other value selects bit 24. Once that bit is 1, the run stops with the saturation flag set and the result equal to 2^(L+9)+1.
- R8: The done flag is set and a one-cycle done pulse is given when GET_RESULT (0x0E) returns to IDLE. In IDLE, both flags are cleared by a run command, and both flags and the result are cleared by the clear command.
- R9: With skipping enabled, the load value is copied into the remaining count when a run is accepted. The block waits in 0x04 for the start and then in 0x0C for stops. There, each stop event decrements a nonzero remaining count and is otherwise ignored. The first stop event seen while the count is zero ends the run. Without skipping, the waiting codes are 0x00 and 0x08.
- R10: A write to the remaining count replaces it only while the count is nonzero. A write in the same cycle as a stop-event decrement takes priority over the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count per cycle |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd | input | 2 | Command code (R2) |
| ev_bus | input | 62 | Event lines selectable by codes 0..61 |
| pre_evt | input | 1 | Prescaler output, selected by code 62 |
| start_sel | input | 6 | Start source code |
| start_pol | input | 1 | Start polarity, 1 = active-low |
| stop_sel | input | 6 | Stop source code |
| stop_pol | input | 1 | Stop polarity, 1 = active-low |
| sat_limit | input | 4 | Saturation bit selector |
| skip_en | input | 1 | Enable the stop-skip counter |
| skip_load_val | input | 16 | Skip count loaded at run start |
| skip_wr | input | 1 | Write strobe for the remaining count |
| skip_wr_val | input | 16 | Value written to the remaining count |
| state_code | output | 6 | Current state code |
| done_flag | output | 1 | Measurement complete |
| sat_flag | output | 1 | Measurement ended by saturation |
| done_pulse | output | 1 | One-cycle completion pulse |
| result | output | 25 | Captured count |
| skip_remaining | output | 16 | Live remaining skip count |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a software write of the remaining skip count and a stop event that would decrement it. The bench drives the write strobe and the stop rising edge on the same edge, and it passes only if the remaining count equals the written value rather than that value minus one. The second pair is an abort and the counter-clear phase. The bench strobes abort during CLR_CNT and again during WAIT_CLR_CNT_DONE, and it passes only if the state codes continue through the clear phases to WAIT_START.

// File: rtl/tim_pkg.sv
`timescale 1ns/1ps
package tim_pkg;
  typedef enum logic [5:0] {
    ST_WSTART    = 6'h00,
    ST_WSTART_SK = 6'h04,
    ST_IDLE      = 6'h06,
    ST_CLR       = 6'h07,
    ST_WSTOP     = 6'h08,
    ST_WSTOP_SK  = 6'h0C,
    ST_RESULT    = 6'h0E,
    ST_POR       = 6'h0F,
    ST_CLR_WAIT  = 6'h16,
    ST_ARM       = 6'h1E,
    ST_FORCE     = 6'h2E
  } tim_state_e;

  typedef enum logic [1:0] {
    CMD_CLEAR     = 2'd0,
    CMD_RUN_EDGE  = 2'd1,
    CMD_RUN_LEVEL = 2'd2,
    CMD_ABORT     = 2'd3
  } tim_cmd_e;
endpackage

// File: rtl/tim_event_pick.sv
`timescale 1ns/1ps
module tim_event_pick #(
  parameter int SEL_W = 6,
  parameter int N_BUS = 62
) (
  input  logic [N_BUS-1:0] bus,
  input  logic             pre_evt,
  input  logic [SEL_W-1:0] sel,
  input  logic             pol,
  output logic             active
);
  localparam int FULL_N = 2**SEL_W;
  logic [FULL_N-1:0] full;

  always_comb begin
    full = '0;
    full[N_BUS-1:0] = bus;
    full[N_BUS] = pre_evt;
  end

  assign active = full[sel] ^ pol;
endmodule

// File: rtl/tim_skip_ctr.sv
`timescale 1ns/1ps
module tim_skip_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic         dec,
  output logic [W-1:0] remaining,
  output logic         zero
);
  logic [W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rem_q <= '0;
    else if (load)             rem_q <= load_val;
    else if (wr && zero == 1'b0) rem_q <= wr_val;
    else if (dec && !zero)     rem_q <= rem_q - 1'b1;
  end

  assign remaining = rem_q;
  assign zero = (rem_q == '0);

  // R10: an exhausted count ignores writes and decrements
  p_zero_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);
  // R9: a stop event without a concurrent write lowers the count by one
  p_dec_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !wr && !load && !zero) |=> (remaining == $past(remaining) - 1'b1));
endmodule

// File: rtl/tim_fast_ctr.sv
`timescale 1ns/1ps
module tim_fast_ctr #(
  parameter int W       = 25,
  parameter int LIM_W   = 4,
  parameter int MIN_BIT = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [LIM_W-1:0] limit,
  output logic [W-1:0]     count,
  output logic             sat_hit
);
  localparam int IDX_W   = $clog2(W);
  localparam int LIM_OFS = (W - 1) - (2**LIM_W - 1);
  localparam int LIM_MIN = MIN_BIT - LIM_OFS;

  logic [W-1:0]     cnt_q;
  logic [IDX_W-1:0] sat_idx;

  always_comb begin
    if (int'(limit) < LIM_MIN) sat_idx = IDX_W'(W - 1);
    else                       sat_idx = IDX_W'(limit) + IDX_W'(LIM_OFS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
  end

  assign count   = cnt_q;
  assign sat_hit = cnt_q[sat_idx];

  // R6: the count only moves while the controller is counting
  p_idle_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(count));
endmodule

// File: rtl/tim_fsm.sv
`timescale 1ns/1ps
module tim_fsm
  import tim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd,
  input  logic       start_act,
  input  logic       stop_edge,
  input  logic       skip_en,
  input  logic       skip_zero,
  input  logic       sat_hit,
  output tim_state_e state,
  output logic       ctr_clr,
  output logic       ctr_run,
  output logic       skip_load,
  output logic       skip_dec,
  output logic       res_cap,
  output logic       res_clr,
  output logic       done_flag,
  output logic       sat_flag,
  output logic       done_pulse
);
  tim_state_e state_q, state_d;
  logic sync_q, stop_by_sat;
  logic run_req, abort_req, clear_req, counting, abortable;
  logic done_q, sat_q, pulse_q;

  assign run_req   = cmd_valid && (cmd == CMD_RUN_EDGE || cmd == CMD_RUN_LEVEL);
  assign abort_req = cmd_valid && (cmd == CMD_ABORT);
  assign clear_req = cmd_valid && (cmd == CMD_CLEAR);
  assign counting  = (state_q == ST_WSTOP) || (state_q == ST_WSTOP_SK);
  assign abortable = (state_q == ST_ARM) || (state_q == ST_WSTART) ||
                     (state_q == ST_WSTART_SK) || counting;

  always_comb begin
    state_d     = state_q;
    stop_by_sat = 1'b0;
    if (abortable && abort_req) begin
      state_d = ST_FORCE;
    end else begin
      case (state_q)
        ST_POR:      state_d = ST_IDLE;
        ST_IDLE:     if (run_req) state_d = ST_CLR;
        ST_CLR:      state_d = ST_CLR_WAIT;
        ST_CLR_WAIT: begin
          if (sync_q)       state_d = ST_ARM;
          else if (skip_en) state_d = ST_WSTART_SK;
          else              state_d = ST_WSTART;
        end
        ST_ARM: begin
          if (!start_act) state_d = skip_en ? ST_WSTART_SK : ST_WSTART;
        end
        ST_WSTART:    if (start_act) state_d = ST_WSTOP;
        ST_WSTART_SK: if (start_act) state_d = ST_WSTOP_SK;
        ST_WSTOP: begin
          if (sat_hit) begin
            state_d = ST_RESULT;
            stop_by_sat = 1'b1;
          end else if (stop_edge) begin
            state_d = ST_RESULT;
          end
        end
        ST_WSTOP_SK: begin
          if (sat_hit) begin
            state_d = ST_RESULT;
            stop_by_sat = 1'b1;
          end else if (stop_edge && skip_zero) begin
            state_d = ST_RESULT;
          end
        end
        ST_RESULT:   state_d = ST_IDLE;
        ST_FORCE:    state_d = ST_IDLE;
        default:     state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POR;
      sync_q  <= 1'b0;
      done_q  <= 1'b0;
      sat_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= (state_q == ST_RESULT);
      if (state_q == ST_IDLE && run_req) sync_q <= (cmd == CMD_RUN_EDGE);
      if (state_q == ST_IDLE && (run_req || clear_req)) begin
        done_q <= 1'b0;
        sat_q  <= 1'b0;
      end
      if (stop_by_sat) sat_q <= 1'b1;
      if (state_q == ST_RESULT) done_q <= 1'b1;
    end
  end

  assign state      = state_q;
  assign ctr_clr    = (state_q == ST_CLR);
  assign ctr_run    = counting;
  assign skip_load  = (state_q == ST_IDLE) && run_req && skip_en;
  assign skip_dec   = (state_q == ST_WSTOP_SK) && stop_edge && !skip_zero;
  assign res_cap    = (state_q == ST_RESULT);
  assign res_clr    = (state_q == ST_IDLE) && (run_req || clear_req);
  assign done_flag  = done_q;
  assign sat_flag   = sat_q;
  assign done_pulse = pulse_q;

  p_por_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POR) |=> (state == ST_IDLE));
  p_idle_stay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !(cmd_valid && (cmd == CMD_RUN_EDGE || cmd == CMD_RUN_LEVEL)))
    |=> (state == ST_IDLE));
  p_force_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FORCE) |=> (state == ST_IDLE && !done_pulse));
  p_clear_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CLR) |=> (state == ST_CLR_WAIT));
  p_sat_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_run && sat_hit && !(cmd_valid && cmd == CMD_ABORT))
    |=> (state == ST_RESULT && sat_flag));
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
endmodule

// File: rtl/time_interval_meter.sv
`timescale 1ns/1ps
module time_interval_meter
  import tim_pkg::*;
#(
  parameter int SEL_W   = 6,
  parameter int RES_W   = 25,
  parameter int LIM_W   = 4,
  parameter int SKIP_W  = 16,
  parameter int MIN_BIT = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd,
  input  logic [(2**SEL_W)-3:0]     ev_bus,
  input  logic                      pre_evt,
  input  logic [SEL_W-1:0]          start_sel,
  input  logic                      start_pol,
  input  logic [SEL_W-1:0]          stop_sel,
  input  logic                      stop_pol,
  input  logic [LIM_W-1:0]          sat_limit,
  input  logic                      skip_en,
  input  logic [SKIP_W-1:0]         skip_load_val,
  input  logic                      skip_wr,
  input  logic [SKIP_W-1:0]         skip_wr_val,
  output logic [5:0]                state_code,
  output logic                      done_flag,
  output logic                      sat_flag,
  output logic                      done_pulse,
  output logic [RES_W-1:0]          result,
  output logic [SKIP_W-1:0]         skip_remaining
);
  localparam int N_BUS = 2**SEL_W - 2;

  logic start_act, stop_act, stop_prev, stop_edge;
  logic ctr_clr, ctr_run, skip_load, skip_dec, res_cap, res_clr;
  logic skip_zero, sat_hit;
  logic [RES_W-1:0] count;
  logic [RES_W-1:0] result_q;
  tim_state_e state;

  tim_event_pick #(.SEL_W(SEL_W), .N_BUS(N_BUS)) u_start_pick (
    .bus(ev_bus), .pre_evt(pre_evt), .sel(start_sel), .pol(start_pol), .active(start_act));
  tim_event_pick #(.SEL_W(SEL_W), .N_BUS(N_BUS)) u_stop_pick (
    .bus(ev_bus), .pre_evt(pre_evt), .sel(stop_sel), .pol(stop_pol), .active(stop_act));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_prev <= 1'b0;
    else        stop_prev <= stop_act;
  end
  assign stop_edge = stop_act && !stop_prev;

  tim_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .start_act(start_act), .stop_edge(stop_edge), .skip_en(skip_en),
    .skip_zero(skip_zero), .sat_hit(sat_hit), .state(state),
    .ctr_clr(ctr_clr), .ctr_run(ctr_run), .skip_load(skip_load),
    .skip_dec(skip_dec), .res_cap(res_cap), .res_clr(res_clr),
    .done_flag(done_flag), .sat_flag(sat_flag), .done_pulse(done_pulse));

  tim_fast_ctr #(.W(RES_W), .LIM_W(LIM_W), .MIN_BIT(MIN_BIT)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .run(ctr_run),
    .limit(sat_limit), .count(count), .sat_hit(sat_hit));

  tim_skip_ctr #(.W(SKIP_W)) u_skip (
    .clk(clk), .rst_n(rst_n), .load(skip_load), .load_val(skip_load_val),
    .wr(skip_wr), .wr_val(skip_wr_val), .dec(skip_dec),
    .remaining(skip_remaining), .zero(skip_zero));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       result_q <= '0;
    else if (res_clr) result_q <= '0;
    else if (res_cap) result_q <= count;
  end

  assign result     = result_q;
  assign state_code = state;

  // R8: done rises exactly together with the completion pulse
  p_done_with_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> done_pulse);
endmodule

// File: tb/time_interval_meter_tb_top.sv
`timescale 1ns/1ps
module time_interval_meter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic [61:0] ev_bus = '0;
  logic        pre_evt = 1'b0;
  logic [5:0]  start_sel = '0;
  logic        start_pol = 1'b0;
  logic [5:0]  stop_sel = 6'd1;
  logic        stop_pol = 1'b0;
  logic [3:0]  sat_limit = 4'd15;
  logic        skip_en = 1'b0;
  logic [15:0] skip_load_val = '0;
  logic        skip_wr = 1'b0;
  logic [15:0] skip_wr_val = '0;
  logic [5:0]  state_code;
  logic        done_flag, sat_flag, done_pulse;
  logic [24:0] result;
  logic [15:0] skip_remaining;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  time_interval_meter dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .ev_bus(ev_bus), .pre_evt(pre_evt), .start_sel(start_sel), .start_pol(start_pol),
    .stop_sel(stop_sel), .stop_pol(stop_pol), .sat_limit(sat_limit),
    .skip_en(skip_en), .skip_load_val(skip_load_val), .skip_wr(skip_wr),
    .skip_wr_val(skip_wr_val), .state_code(state_code), .done_flag(done_flag),
    .sat_flag(sat_flag), .done_pulse(done_pulse), .result(result),
    .skip_remaining(skip_remaining));

  typedef struct packed {
    logic       sync;
    logic       pre;
    logic [5:0] ssel;
    logic       spol;
    logic [5:0] psel;
    logic       ppol;
    logic [7:0] n;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{1'b0, 1'b0, 6'd3,  1'b0, 6'd7,  1'b0, 8'd5},
    '{1'b1, 1'b0, 6'd10, 1'b1, 6'd20, 1'b0, 8'd9},
    '{1'b0, 1'b1, 6'd4,  1'b0, 6'd5,  1'b1, 8'd6},
    '{1'b1, 1'b1, 6'd0,  1'b0, 6'd61, 1'b0, 8'd12},
    '{1'b0, 1'b0, 6'd62, 1'b0, 6'd33, 1'b1, 8'd3},
    '{1'b1, 1'b0, 6'd8,  1'b0, 6'd8,  1'b1, 8'd7}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_line(input int idx, input logic v);
    if (idx < 62) ev_bus[idx] = v;
    else if (idx == 62) pre_evt = v;
  endtask

  task automatic issue(input logic [1:0] c);
    cmd_valid = 1'b1;
    cmd = c;
    tick(1);
    cmd_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(3);
    chk("R1 state in reset", state_code, 32'h0F);
    chk("R1 flags in reset", {done_flag, sat_flag}, 0);
    chk("R1 result in reset", result, 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 idle after release", state_code, 32'h06);
    tick(2);

    // R4 R5 R6 table walk
    for (int i = 0; i < 6; i++) begin
      vec_t v;
      v = VEC[i];
      start_sel = v.ssel; start_pol = v.spol;
      stop_sel = v.psel; stop_pol = v.ppol;
      set_line(v.psel, v.ppol);
      set_line(v.ssel, v.pre ? ~v.spol : v.spol);
      tick(2);
      issue(v.sync ? 2'd1 : 2'd2);
      tick(3);
      if (v.pre && !v.sync) begin
        tick(int'(v.n) - 1);
      end else begin
        if (v.pre) begin
          set_line(v.ssel, v.spol);
          tick(2);
        end
        set_line(v.ssel, ~v.spol);
        tick(int'(v.n));
      end
      set_line(v.psel, ~v.ppol);
      tick(3);
      chk($sformatf("R6 R4 R5 vector %0d result", i), result, {24'd0, v.n});
      chk($sformatf("R8 vector %0d done", i), {sat_flag, done_flag}, 1);
      ev_bus = '0; pre_evt = 1'b0;
      tick(2);
    end

    // R8 clear command
    issue(2'd0);
    tick(1);
    chk("R8 clear result", result, 0);
    chk("R8 clear done", done_flag, 0);

    // R11-style code walk and abort (R2)
    start_sel = 6'd2; start_pol = 1'b0; stop_sel = 6'd3; stop_pol = 1'b0;
    issue(2'd1);
    chk("R3 clr phase", state_code, 32'h07);
    tick(1);
    chk("R3 clr wait", state_code, 32'h16);
    tick(1);
    chk("R4 arm", state_code, 32'h1E);
    tick(1);
    chk("R4 wait start", state_code, 32'h00);
    issue(2'd3);
    chk("R2 force stop", state_code, 32'h2E);
    tick(1);
    chk("R2 idle after abort", state_code, 32'h06);
    chk("R2 no done after abort", done_flag, 0);
    issue(2'd0);
    chk("R2 clear keeps idle", state_code, 32'h06);

    // R3 abort ignored during clear phases
    issue(2'd2);
    issue(2'd3);
    chk("R3 abort in CLR_CNT", state_code, 32'h16);
    issue(2'd3);
    chk("R3 abort in WAIT_CLR", state_code, 32'h00);
    issue(2'd3);
    tick(2);

    // R7 saturation at bit 12
    sat_limit = 4'd3;
    ev_bus[2] = 1'b1;
    issue(2'd2);
    tick(4300);
    chk("R7 sat result", result, 4097);
    chk("R7 sat flag", {sat_flag, done_flag}, 3);
    issue(2'd0);
    chk("R8 clear sat", sat_flag, 0);

    // R7 unsupported limit behaves as bit 24
    sat_limit = 4'd0;
    issue(2'd2);
    tick(5000);
    chk("R7 unsupported limit keeps counting", state_code, 32'h08);
    chk("R7 unsupported no sat", sat_flag, 0);
    issue(2'd3);
    tick(1);
    ev_bus = '0;
    sat_limit = 4'd15;
    tick(2);

    // R9 skip two stops
    skip_en = 1'b1; skip_load_val = 16'd2;
    start_sel = 6'd1; stop_sel = 6'd2;
    issue(2'd2);
    tick(2);
    chk("R9 wait start skip code", state_code, 32'h04);
    chk("R9 loaded", skip_remaining, 2);
    ev_bus[1] = 1'b1;
    tick(1);
    chk("R9 countdown code", state_code, 32'h0C);
    tick(2);
    ev_bus[2] = 1'b1; tick(1);
    chk("R9 first skip", skip_remaining, 1);
    ev_bus[2] = 1'b0; tick(1);
    ev_bus[2] = 1'b1; tick(1);
    ev_bus[2] = 1'b0; tick(1);
    ev_bus[2] = 1'b1; tick(1);
    ev_bus[2] = 1'b0; tick(1);
    chk("R8 done pulse high", done_pulse, 1);
    tick(1);
    chk("R8 done pulse low", done_pulse, 0);
    chk("R9 skip result", result, 7);
    chk("R9 remaining zero", skip_remaining, 0);

    // R10 write ignored when zero
    skip_wr = 1'b1; skip_wr_val = 16'd9;
    tick(1);
    skip_wr = 1'b0;
    chk("R10 write ignored at zero", skip_remaining, 0);

    // R10 live write and same-cycle priority
    ev_bus = '0;
    skip_load_val = 16'd3;
    tick(2);
    issue(2'd2);
    tick(2);
    ev_bus[1] = 1'b1; tick(1);
    ev_bus[2] = 1'b1; tick(1);
    chk("R9 decrement", skip_remaining, 2);
    ev_bus[2] = 1'b0; skip_wr = 1'b1; skip_wr_val = 16'd5; tick(1);
    skip_wr = 1'b0;
    chk("R10 live write", skip_remaining, 5);
    ev_bus[2] = 1'b1; skip_wr = 1'b1; skip_wr_val = 16'd1; tick(1);
    skip_wr = 1'b0;
    chk("R10 write beats decrement", skip_remaining, 1);
    ev_bus[2] = 1'b0; tick(1);
    ev_bus[2] = 1'b1; tick(1);
    chk("R9 still counting down", state_code, 32'h0C);
    ev_bus[2] = 1'b0; tick(1);
    ev_bus[2] = 1'b1; tick(1);
    ev_bus[2] = 1'b0; tick(2);
    chk("R10 final result", result, 7);
    chk("R9 done after count", done_flag, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule